// File: doc/BRIEF.md
# Outstanding-Miss Tracker

This block keeps a small table of cache misses that are waiting on the next memory level. It sits beside a non-blocking cache. When the cache misses, it presents the line address and a requester tag. If no live entry holds that line, the tracker claims a free entry and asks the next level for the line exactly once. A later miss to a line that is already waiting joins the list of requesters on that entry, and no second request goes out.

When the next level answers, the response names the entry index. The tracker then hands back the waiting requester tags, one per cycle, in the order they joined, and frees the entry after the last one. The tracker raises `full` when every entry is taken, so the cache holds back new misses. Hits are never routed through the tracker, so they keep flowing while misses are outstanding.

The data array and the replacement choice are handled elsewhere. Entry count, line-address width, tag width and waiter-list depth are all parameters.

Top module: `miss_tracker`

## Requirements
- R1: After reset, `full`, `fill_req_valid` and `release_valid` are 0, and a request is neither accepted nor refused while `req_valid` is 0.
- R2: A miss whose line matches no waiting or issued entry, while a free entry exists, is accepted in the same cycle (`req_accept`=1, `req_merged`=0). It takes the lowest-indexed free entry. From the next cycle, `fill_req_valid` is 1 with that line on `fill_req_line` and that entry's index on `fill_req_idx`.
- R3: A miss whose line matches an entry that is waiting to issue or already issued is merged (`req_accept`=1, `req_merged`=1). At most one fill request is ever made per entry, and no fill is requested for a line that already has an issued entry.
- R4: Each entry holds at most 4 requester tags. A merge into an entry that already has 4 is refused (`req_accept`=0, `req_retry`=1), and the refused tag is never released.
- R5: `full` is 1 exactly when no entry is free. A new-line miss while full is refused with `req_retry`=1. A merge into a live entry is still accepted while full.
- R6: A fill request stays asserted until it is taken by `fill_req_ready`=1. After a fill response for entry k in cycle t, the entry's tags come out on `release_tag` (with its line on `release_line`) in cycles t+1, t+2, … in the order they were accepted. The entry is free again in the cycle after its last release.
- R7: When several entries wait to issue, the one with the lowest index is presented first.
- R8: Only one tag is released per cycle. When several entries are releasing, the lowest-indexed entry is served first.
- R9: A miss to a line whose entry is already releasing is not merged. It is treated as a new-line miss and gets its own entry and fill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A cache miss is presented |
| req_line | input | LINE_AW | Line address of the miss |
| req_tag | input | TAG_W | Requester tag of the miss |
| req_accept | output | 1 | Miss taken this cycle |
| req_merged | output | 1 | Miss joined an existing entry |
| req_retry | output | 1 | Miss refused; requester must present it again |
| full | output | 1 | No free entry |
| fill_req_valid | output | 1 | Fill request to next level pending |
| fill_req_ready | input | 1 | Next level takes the fill request |
| fill_req_line | output | LINE_AW | Line address to fetch |
| fill_req_idx | output | log2(NUM_ENTRIES) | Entry index carried with the fill |
| fill_rsp_valid | input | 1 | Fill has returned |
| fill_rsp_idx | input | log2(NUM_ENTRIES) | Entry the returning fill belongs to |
| release_valid | output | 1 | A waiting requester is released |
| release_line | output | LINE_AW | Line of the released requester |
| release_tag | output | TAG_W | Tag of the released requester |

## Verification
A single line is hit repeatedly so that one entry goes through its whole life: allocation, one merge before the fill request is taken, two merges after it, a refused fifth merge, and release in order. This separates a merge from a duplicate allocation and shows that the refused tag is never recorded. Eight distinct lines fill the table, which checks the full flag, refusal of a new line and acceptance of a merge while full. The same run checks the lowest-index issue order and the release order when two entries return back to back. A last pattern sends a miss to a line whose entry is already releasing, and expects a new entry rather than a merge.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    // Life of one tracking entry.
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,   // allocated, fill not yet taken
        ENT_PEND  = 2'd2,   // fill taken by next level
        ENT_DRAIN = 2'd3    // fill back, releasing waiters
    } ent_state_e;

endpackage

// File: rtl/mshr_pick.sv
// Lowest-index selector over a request vector.
module mshr_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/mshr_lookup.sv
// Parallel line-address compare against all live entries.
module mshr_lookup #(
    parameter int N  = 8,
    parameter int AW = 26,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][AW-1:0] lines_i,
    input  logic [N-1:0]         live_i,
    input  logic [AW-1:0]        probe_i,
    output logic [N-1:0]         hit_vec_o,
    output logic                 hit_o,
    output logic [IW-1:0]        hit_idx_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = live_i[g] && (lines_i[g] == probe_i);
    end

    mshr_pick #(.N(N), .IW(IW)) u_hit_pick (
        .req_i (hit_vec_o),
        .any_o (hit_o),
        .idx_o (hit_idx_o)
    );

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
    import mshr_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int LINE_AW     = 26,
    parameter int TAG_W       = 6,
    parameter int MAX_WAIT    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [LINE_AW-1:0]             req_line,
    input  logic [TAG_W-1:0]               req_tag,
    output logic                           req_accept,
    output logic                           req_merged,
    output logic                           req_retry,
    output logic                           full,
    output logic                           fill_req_valid,
    input  logic                           fill_req_ready,
    output logic [LINE_AW-1:0]             fill_req_line,
    output logic [$clog2(NUM_ENTRIES)-1:0] fill_req_idx,
    input  logic                           fill_rsp_valid,
    input  logic [$clog2(NUM_ENTRIES)-1:0] fill_rsp_idx,
    output logic                           release_valid,
    output logic [LINE_AW-1:0]             release_line,
    output logic [TAG_W-1:0]               release_tag
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int CNT_W = $clog2(MAX_WAIT + 1);
    localparam int PTR_W = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WAIT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        ent_state_e                       st;
        logic [LINE_AW-1:0]               line;
        logic [MAX_WAIT-1:0][TAG_W-1:0]   tags;
        logic [CNT_W-1:0]                 cnt;
        logic [PTR_W-1:0]                 head;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_ENTRIES-1:0] ents;
    } state_t;

    state_t state_d, state_q;

    // ---------------------------------------------------------------
    // Per-entry status vectors
    // ---------------------------------------------------------------
    logic [NUM_ENTRIES-1:0]              live_vec, free_vec, wait_vec, drain_vec;
    logic [NUM_ENTRIES-1:0][LINE_AW-1:0] line_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_stat
        assign free_vec[g]  = (state_q.ents[g].st == ENT_FREE);
        assign wait_vec[g]  = (state_q.ents[g].st == ENT_WAIT);
        assign drain_vec[g] = (state_q.ents[g].st == ENT_DRAIN);
        assign live_vec[g]  = (state_q.ents[g].st == ENT_WAIT) ||
                              (state_q.ents[g].st == ENT_PEND);
        assign line_vec[g]  = state_q.ents[g].line;
    end

    // ---------------------------------------------------------------
    // Address match and selectors
    // ---------------------------------------------------------------
    logic [NUM_ENTRIES-1:0] match_vec;
    logic                   match_any;
    logic [IDX_W-1:0]       match_idx;

    mshr_lookup #(.N(NUM_ENTRIES), .AW(LINE_AW), .IW(IDX_W)) u_lookup (
        .lines_i   (line_vec),
        .live_i    (live_vec),
        .probe_i   (req_line),
        .hit_vec_o (match_vec),
        .hit_o     (match_any),
        .hit_idx_o (match_idx)
    );

    logic             free_any,  wait_any,  drain_any;
    logic [IDX_W-1:0] free_idx,  wait_idx,  drain_idx;

    mshr_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_free_pick (
        .req_i (free_vec),  .any_o (free_any),  .idx_o (free_idx)
    );
    mshr_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_issue_pick (
        .req_i (wait_vec),  .any_o (wait_any),  .idx_o (wait_idx)
    );
    mshr_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_drain_pick (
        .req_i (drain_vec), .any_o (drain_any), .idx_o (drain_idx)
    );

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    entry_t           fresh;
    logic [CNT_W-1:0] merge_cnt;
    logic [CNT_W-1:0] drain_cnt;
    logic [PTR_W-1:0] drain_head;

    always_comb begin
        state_d    = state_q;
        req_accept = 1'b0;
        req_merged = 1'b0;
        req_retry  = 1'b0;

        fresh         = '0;
        fresh.st      = ENT_WAIT;
        fresh.line    = req_line;
        fresh.tags[0] = req_tag;
        fresh.cnt     = CNT_ONE;

        merge_cnt  = state_q.ents[match_idx].cnt;
        drain_cnt  = state_q.ents[drain_idx].cnt;
        drain_head = state_q.ents[drain_idx].head;

        // Incoming miss: merge, allocate or refuse.
        if (req_valid) begin
            if (match_any) begin
                if (merge_cnt < CNT_MAX) begin
                    req_accept = 1'b1;
                    req_merged = 1'b1;
                    state_d.ents[match_idx].tags[merge_cnt[PTR_W-1:0]] = req_tag;
                    state_d.ents[match_idx].cnt = merge_cnt + CNT_ONE;
                end else begin
                    req_retry = 1'b1;
                end
            end else if (free_any) begin
                req_accept              = 1'b1;
                state_d.ents[free_idx]  = fresh;
            end else begin
                req_retry = 1'b1;
            end
        end

        // Fill request taken by the next level.
        if (wait_any && fill_req_ready) begin
            state_d.ents[wait_idx].st = ENT_PEND;
        end

        // Fill returned: start releasing waiters.
        if (fill_rsp_valid) begin
            state_d.ents[fill_rsp_idx].st   = ENT_DRAIN;
            state_d.ents[fill_rsp_idx].head = '0;
        end

        // One release per cycle, lowest draining entry first.
        if (drain_any) begin
            if (CNT_W'(drain_head) == drain_cnt - CNT_ONE) begin
                state_d.ents[drain_idx].st   = ENT_FREE;
                state_d.ents[drain_idx].cnt  = '0;
                state_d.ents[drain_idx].head = '0;
            end else begin
                state_d.ents[drain_idx].head = drain_head + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    assign full           = !free_any;
    assign fill_req_valid = wait_any;
    assign fill_req_idx   = wait_idx;
    assign fill_req_line  = state_q.ents[wait_idx].line;
    assign release_valid  = drain_any;
    assign release_line   = state_q.ents[drain_idx].line;
    assign release_tag    = state_q.ents[drain_idx].tags[drain_head];

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic                   dup_pend;
    logic                   over_cap;
    logic [NUM_ENTRIES-1:0] lower_mask;

    always_comb begin
        dup_pend = 1'b0;
        over_cap = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (state_q.ents[i].st == ENT_PEND &&
                state_q.ents[i].line == fill_req_line) begin
                dup_pend = 1'b1;
            end
            if (state_q.ents[i].cnt > CNT_MAX) begin
                over_cap = 1'b1;
            end
        end
        lower_mask = (NUM_ENTRIES'(1) << fill_req_idx) - NUM_ENTRIES'(1);
    end

    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    assert_no_dup_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> !dup_pend);

    assert_waiter_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !over_cap);

    assert_full_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && full && !match_any) |-> (req_retry && !req_accept));

    assert_rsp_to_issued_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_rsp_valid |-> (state_q.ents[fill_rsp_idx].st == ENT_PEND));

    assert_issue_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && !fill_req_ready) |=> fill_req_valid);

    assert_issue_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> ((wait_vec & lower_mask) == '0));

endmodule

// File: tb/miss_tracker_test.sv
`timescale 1ns/1ps
module miss_tracker_test;

    localparam int N  = 8;
    localparam int AW = 26;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_line = '0;
    logic [TW-1:0] req_tag = '0;
    logic          req_accept, req_merged, req_retry, full;
    logic          fill_req_valid;
    logic          fill_req_ready = 1'b0;
    logic [AW-1:0] fill_req_line;
    logic [2:0]    fill_req_idx;
    logic          fill_rsp_valid = 1'b0;
    logic [2:0]    fill_rsp_idx = '0;
    logic          release_valid;
    logic [AW-1:0] release_line;
    logic [TW-1:0] release_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    miss_tracker #(.NUM_ENTRIES(N), .LINE_AW(AW), .TAG_W(TW), .MAX_WAIT(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_line(req_line), .req_tag(req_tag),
        .req_accept(req_accept), .req_merged(req_merged), .req_retry(req_retry),
        .full(full),
        .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
        .fill_req_line(fill_req_line), .fill_req_idx(fill_req_idx),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_idx(fill_rsp_idx),
        .release_valid(release_valid), .release_line(release_line),
        .release_tag(release_tag)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        fill_req_ready = 1'b0;
        fill_rsp_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic present(input logic [AW-1:0] l, input logic [TW-1:0] t);
        req_valid = 1'b1;
        req_line  = l;
        req_tag   = t;
    endtask

    // R1: idle state after reset
    task automatic test_reset();
        do_reset();
        #1;
        chk("R1", "full", full, 0);
        chk("R1", "fill_req_valid", fill_req_valid, 0);
        chk("R1", "release_valid", release_valid, 0);
        chk("R1", "req_accept idle", req_accept, 0);
        chk("R1", "req_retry idle", req_retry, 0);
    endtask

    // R2 R3 R4 R6: one line through its whole life
    task automatic test_single_line();
        logic [AW-1:0] la = 26'h00123A;
        logic [AW-1:0] lc = 26'h0004C0;
        do_reset();
        cyc(); present(la, 6'd1); #1;
        chk("R2", "primary accept", req_accept, 1);
        chk("R2", "primary not merged", req_merged, 0);
        chk("R2", "no fill same cycle", fill_req_valid, 0);
        cyc(); present(la, 6'd2); #1;
        chk("R2", "fill valid", fill_req_valid, 1);
        chk("R2", "fill idx", fill_req_idx, 0);
        chk("R2", "fill line", fill_req_line, la);
        chk("R3", "merge before issue", {req_accept, req_merged}, 2'b11);
        cyc(); req_valid = 1'b0; fill_req_ready = 1'b1; #1;
        chk("R6", "fill held until taken", fill_req_valid, 1);
        cyc(); fill_req_ready = 1'b0; #1;
        chk("R3", "single fill only", fill_req_valid, 0);
        cyc(); present(la, 6'd3); #1;
        chk("R3", "merge after issue", {req_accept, req_merged}, 2'b11);
        cyc(); present(la, 6'd4); #1;
        chk("R3", "fourth merge", {req_accept, req_merged}, 2'b11);
        chk("R3", "no duplicate fill", fill_req_valid, 0);
        cyc(); present(la, 6'd5); #1;
        chk("R4", "fifth refused accept", req_accept, 0);
        chk("R4", "fifth refused retry", req_retry, 1);
        cyc(); req_valid = 1'b0; fill_rsp_valid = 1'b1; fill_rsp_idx = 3'd0; #1;
        chk("R6", "no release same cycle", release_valid, 0);
        cyc(); fill_rsp_valid = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            if (k > 1) cyc();
            #1;
            chk("R6", "release valid", release_valid, 1);
            chk("R6", "release tag order", release_tag, k);
            chk("R6", "release line", release_line, la);
        end
        cyc(); #1;
        chk("R4", "refused tag never released", release_valid, 0);
        chk("R6", "not full after free", full, 0);
        cyc(); present(lc, 6'd7); #1;
        chk("R2", "realloc accept", {req_accept, req_merged}, 2'b10);
        cyc(); req_valid = 1'b0; #1;
        chk("R6", "freed entry reused idx", fill_req_idx, 0);
        chk("R2", "realloc line", fill_req_line, lc);
    endtask

    // R5 R7 R8: table full, issue and release ordering
    task automatic test_full_table();
        logic [AW-1:0] base = 26'h0100000;
        do_reset();
        for (int i = 0; i < N; i++) begin
            cyc(); present(base + AW'(i), TW'(i)); #1;
            chk("R2", "fill table accept", req_accept, 1);
        end
        cyc(); present(26'h0222222, 6'd30); #1;
        chk("R5", "full raised", full, 1);
        chk("R5", "new line refused", {req_accept, req_retry}, 2'b01);
        cyc(); present(base, 6'd20); #1;
        chk("R5", "merge while full", {req_accept, req_merged}, 2'b11);
        cyc(); req_valid = 1'b0; fill_req_ready = 1'b1; #1;
        chk("R7", "first issue idx", fill_req_idx, 0);
        for (int i = 1; i < N; i++) begin
            cyc(); #1;
            chk("R7", "issue order idx", fill_req_idx, i);
            chk("R7", "issue order line", fill_req_line, base + AW'(i));
        end
        cyc(); fill_req_ready = 1'b0; #1;
        chk("R7", "all issued", fill_req_valid, 0);
        cyc(); fill_rsp_valid = 1'b1; fill_rsp_idx = 3'd0; #1;
        chk("R8", "nothing before response", release_valid, 0);
        cyc(); fill_rsp_idx = 3'd5; #1;
        chk("R8", "entry0 first tag", release_tag, 0);
        cyc(); fill_rsp_valid = 1'b0; #1;
        chk("R8", "lower entry served first", release_tag, 20);
        chk("R8", "lower entry line", release_line, base);
        cyc(); #1;
        chk("R8", "then entry5 tag", release_tag, 5);
        chk("R8", "entry5 line", release_line, base + AW'(5));
        cyc(); #1;
        chk("R8", "releases done", release_valid, 0);
        chk("R5", "full cleared", full, 0);
    endtask

    // R9: miss to a releasing line is a new primary
    task automatic test_drain_line();
        logic [AW-1:0] ld = 26'h0033330;
        do_reset();
        cyc(); present(ld, 6'd1);
        cyc(); present(ld, 6'd2);
        cyc(); req_valid = 1'b0; fill_req_ready = 1'b1;
        cyc(); fill_req_ready = 1'b0; fill_rsp_valid = 1'b1; fill_rsp_idx = 3'd0;
        cyc(); fill_rsp_valid = 1'b0; present(ld, 6'd9); #1;
        chk("R6", "first waiter", release_tag, 1);
        chk("R9", "draining line new primary", {req_accept, req_merged}, 2'b10);
        cyc(); req_valid = 1'b0; #1;
        chk("R6", "second waiter", release_tag, 2);
        chk("R9", "second fill valid", fill_req_valid, 1);
        chk("R9", "second fill idx", fill_req_idx, 1);
        chk("R9", "second fill line", fill_req_line, ld);
    endtask

    initial begin
        test_reset();
        test_single_line();
        test_full_table();
        test_drain_line();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule